// File: doc/BRIEF.md
# Dual-Layout Image Address Generator

This block produces memory addresses for a square image of 256 by 256 pixels kept in a 16-bit address space. The image may sit in memory in one of two layouts: row after row, or cut into 16 by 16 pixel tiles with the tiles placed one after another. Software can name a pixel in either of two ways, whatever the layout. The linear way uses a row byte and a column byte. The tiled way uses a tile byte and an in-tile offset byte. The block translates between the two forms as needed.

One address register is held in linear form. A 3-bit command selects the action: clear the register, load it from the register file or from an immediate, hold it, or step one or both halves. A mode input says how loaded values and steps are to be read. A layout input says how the image is stored, and so decides the form of the outgoing address. Layout conversion in either direction exchanges the low nibble of the upper byte with the high nibble of the lower byte. The conversion is therefore its own inverse.

Top module: `agu_image_addr`

## Requirements
- R1: While reset is asserted and right after it, the register is zero, so the address output is 0x0000 in both layouts.
- R2: Command 0 sets the register to zero on the next rising clock edge.
- R3: Command 2 loads the register-file value. With mode 0 it is stored as given, as row in bits [15:8] and column in bits [7:0].
- R4: With mode 1, a loaded value is read as tile in bits [15:8] and offset in bits [7:0]. Its bits [11:8] and [7:4] are exchanged before it is stored, so a layout-1 output later returns the loaded value.
- R5: Command 3 loads the immediate in the same way as command 2 loads the register-file value, for both modes.
- R6: With layout input 0 the address is the register. With layout input 1 it is the register with bits [11:8] and [7:4] exchanged, so linear 0x0202 gives 0x0022 (34) under layout 1 and 0x0202 (514) under layout 0.
- R7: Commands 1 and 4 leave the register unchanged.
- R8: Command 5 adds 0x0100 to the register as read in the selected mode: to the row when mode is 0, to the tile when mode is 1.
- R9: Command 6 adds 0x0001 in the selected mode. A carry out of the lower byte moves to the first pixel of the next row (mode 0) or of the next tile (mode 1).
- R10: Command 7 adds 0x0101 in the selected mode.
- R11: All steps wrap modulo 2^16.
- R12: During a command the address output shows the register value from before the command. The new value appears after the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Command code (0 to 7, see R2 to R10) |
| mode_i | input | 1 | Interpretation: 0 row/column, 1 tile/offset |
| format_i | input | 1 | Storage layout: 0 row-linear, 1 tiled |
| rf_i | input | 16 | Register-file value for command 2 |
| imm_i | input | 16 | Immediate value for command 3 |
| addr_o | output | 16 | Memory address |

## Verification
A chained sequence starts from 0x0202. It applies a tile step, a column step, a row step and a combined step under tiled storage, giving 34, 290, 291, 307 and 564. Mixing the modes within one sequence exposes a step applied in the wrong form. Column 0xFF and offset 0xFF inputs separate a correct carry into the next row or tile from a truncated one. An all-ones start shows the modulo wrap. A loaded value whose four nibbles all differ (0xABCD) shows that exactly the two middle nibbles are exchanged. Hold, clear, mid-run reset and the output during a step command are checked separately.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    OP_CLEAR    = 3'd0,
    OP_NOP      = 3'd1,
    OP_LD_RF    = 3'd2,
    OP_LD_IMM   = 3'd3,
    OP_ACCESS   = 3'd4,
    OP_INC_HI   = 3'd5,
    OP_INC_LO   = 3'd6,
    OP_INC_BOTH = 3'd7
  } agu_op_e;

endpackage

// File: rtl/agu_tile_swap.sv
// Linear <-> tiled conversion: exchange low part of the upper half with the
// high part of the lower half. Self-inverse when both parts are equally wide.
module agu_tile_swap #(
  parameter int HALF_W = 8
) (
  input  logic [2*HALF_W-1:0] in_i,
  output logic [2*HALF_W-1:0] out_o
);
  localparam int ADDR_W = 2 * HALF_W;
  localparam int PART_W = HALF_W / 2;

  generate
    if (HALF_W % 2 != 0) begin : g_bad_width
      initial $fatal(1, "HALF_W must be even");
    end
  endgenerate

  logic [PART_W-1:0] up_hi, up_lo, dn_hi, dn_lo;

  always_comb begin
    up_hi = in_i[ADDR_W-1 -: PART_W];
    up_lo = in_i[HALF_W+PART_W-1 -: PART_W];
    dn_hi = in_i[HALF_W-1 -: PART_W];
    dn_lo = in_i[PART_W-1:0];
    out_o = {up_hi, dn_hi, up_lo, dn_lo};
  end

endmodule

// File: rtl/agu_step.sv
// Post-increment unit: steps the address in the mode-selected form.
module agu_step
  import agu_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic [2*HALF_W-1:0] ar_i,
  input  agu_op_e             op_i,
  input  logic                mode_i,
  output logic [2*HALF_W-1:0] next_o
);
  localparam int ADDR_W = 2 * HALF_W;
  localparam logic [ADDR_W-1:0] INC_HI   = ADDR_W'(1) << HALF_W;
  localparam logic [ADDR_W-1:0] INC_LO   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] INC_BOTH = INC_HI | INC_LO;

  logic [ADDR_W-1:0] ar_blk, work, inc, sum, sum_lin;

  agu_tile_swap #(.HALF_W(HALF_W)) u_to_blk (.in_i(ar_i), .out_o(ar_blk));
  agu_tile_swap #(.HALF_W(HALF_W)) u_to_lin (.in_i(sum),  .out_o(sum_lin));

  always_comb begin
    case (op_i)
      OP_INC_HI:   inc = INC_HI;
      OP_INC_LO:   inc = INC_LO;
      OP_INC_BOTH: inc = INC_BOTH;
      default:     inc = '0;
    endcase
    work   = mode_i ? ar_blk : ar_i;
    sum    = work + inc;
    next_o = mode_i ? sum_lin : sum;
  end

endmodule

// File: rtl/agu_addr_reg.sv
// Address register held in linear form, with load conversion.
module agu_addr_reg
  import agu_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  agu_op_e             op_i,
  input  logic                mode_i,
  input  logic [2*HALF_W-1:0] rf_i,
  input  logic [2*HALF_W-1:0] imm_i,
  input  logic [2*HALF_W-1:0] step_i,
  output logic [2*HALF_W-1:0] ar_o
);
  localparam int ADDR_W = 2 * HALF_W;

  logic [ADDR_W-1:0] ar_q, ar_d, ld_raw, ld_cnv, ld_lin;
  logic              ar_en;

  agu_tile_swap #(.HALF_W(HALF_W)) u_ld_cnv (.in_i(ld_raw), .out_o(ld_cnv));

  always_comb begin
    ld_raw = (op_i == OP_LD_IMM) ? imm_i : rf_i;
    ld_lin = mode_i ? ld_cnv : ld_raw;
    ar_en  = 1'b1;
    ar_d   = ar_q;
    case (op_i)
      OP_CLEAR:                         ar_d = '0;
      OP_LD_RF, OP_LD_IMM:              ar_d = ld_lin;
      OP_INC_HI, OP_INC_LO, OP_INC_BOTH: ar_d = step_i;
      default:                          ar_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_q <= '0;
    end else if (ar_en) begin
      ar_q <= ar_d;
    end
  end

  assign ar_o = ar_q;

  assert_clear_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CLEAR) |=> (ar_q == '0));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_NOP || op_i == OP_ACCESS) |=> $stable(ar_q));

  assert_load_rf_lin_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LD_RF && !mode_i) |=> (ar_q == $past(rf_i)));

endmodule

// File: rtl/agu_image_addr.sv
// Top: dual-layout image address generator.
module agu_image_addr
  import agu_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          op_i,
  input  logic                mode_i,
  input  logic                format_i,
  input  logic [2*HALF_W-1:0] rf_i,
  input  logic [2*HALF_W-1:0] imm_i,
  output logic [2*HALF_W-1:0] addr_o
);
  localparam int ADDR_W = 2 * HALF_W;
  localparam logic [ADDR_W-1:0] STEP_HI   = ADDR_W'(1) << HALF_W;
  localparam logic [ADDR_W-1:0] STEP_BOTH = STEP_HI | ADDR_W'(1);

  agu_op_e           op;
  logic [ADDR_W-1:0] ar, ar_blk, step_next;

  assign op = agu_op_e'(op_i);

  agu_step #(.HALF_W(HALF_W)) u_step (
    .ar_i  (ar),
    .op_i  (op),
    .mode_i(mode_i),
    .next_o(step_next)
  );

  agu_addr_reg #(.HALF_W(HALF_W)) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .mode_i(mode_i),
    .rf_i  (rf_i),
    .imm_i (imm_i),
    .step_i(step_next),
    .ar_o  (ar)
  );

  agu_tile_swap #(.HALF_W(HALF_W)) u_out_cnv (.in_i(ar), .out_o(ar_blk));

  always_comb begin
    addr_o = format_i ? ar_blk : ar;
  end

  assert_inc_hi_lin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_INC_HI && !mode_i) |=> (ar == $past(ar) + STEP_HI));

  assert_inc_lo_blk_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_INC_LO && mode_i) |=> (ar_blk == $past(ar_blk) + ADDR_W'(1)));

  assert_inc_both_blk_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_INC_BOTH && mode_i) |=> (ar_blk == $past(ar_blk) + STEP_BOTH));

  assert_load_imm_blk_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_LD_IMM && mode_i) |=> (ar_blk == $past(imm_i)));

endmodule

// File: tb/agu_image_addr_tb.sv
module agu_image_addr_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [2:0]  op_i;
  logic        mode_i;
  logic        format_i;
  logic [15:0] rf_i;
  logic [15:0] imm_i;
  logic [15:0] addr_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  agu_image_addr u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .mode_i(mode_i),
    .format_i(format_i), .rf_i(rf_i), .imm_i(imm_i), .addr_o(addr_o)
  );

  // {req[3:0], op[2:0], mode, fmt, rf[15:0], imm[15:0], expected[15:0]}
  localparam int NV = 18;
  localparam logic [56:0] VEC [NV] = '{
    {4'd6,  3'd3, 1'b0, 1'b1, 16'h0000, 16'h0202, 16'h0022}, // R6 load 0x0202 -> 34
    {4'd8,  3'd5, 1'b1, 1'b1, 16'h0000, 16'h0000, 16'h0122}, // R8 tile step -> 290
    {4'd9,  3'd6, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0123}, // R9 column step -> 291
    {4'd8,  3'd5, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0133}, // R8 row step -> 307
    {4'd10, 3'd7, 1'b1, 1'b1, 16'h0000, 16'h0000, 16'h0234}, // R10 both -> 564
    {4'd7,  3'd4, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0324}, // R7 access, linear view
    {4'd7,  3'd1, 1'b1, 1'b1, 16'h0000, 16'h0000, 16'h0234}, // R7 nop
    {4'd3,  3'd2, 1'b0, 1'b0, 16'h12FF, 16'h0000, 16'h12FF}, // R3 load rf linear
    {4'd9,  3'd6, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h1300}, // R9 end of row
    {4'd4,  3'd2, 1'b1, 1'b1, 16'h05FF, 16'h0000, 16'h05FF}, // R4 load rf tiled
    {4'd9,  3'd6, 1'b1, 1'b1, 16'h0000, 16'h0000, 16'h0600}, // R9 end of tile
    {4'd5,  3'd3, 1'b0, 1'b0, 16'h0000, 16'hFFFF, 16'hFFFF}, // R5 load imm
    {4'd11, 3'd7, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0100}, // R11 wrap
    {4'd8,  3'd5, 1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0110}, // R8 tile step, linear view
    {4'd2,  3'd0, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0000}, // R2 clear
    {4'd4,  3'd3, 1'b1, 1'b0, 16'h0000, 16'hABCD, 16'hACBD}, // R4 nibble exchange
    {4'd5,  3'd3, 1'b1, 1'b1, 16'h0000, 16'hFFFF, 16'hFFFF}, // R5 load imm tiled
    {4'd11, 3'd5, 1'b1, 1'b1, 16'h0000, 16'h0000, 16'h00FF}  // R11 tile wrap
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: addr actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; op_i = 3'd1; mode_i = 1'b0; format_i = 1'b0;
    rf_i = '0; imm_i = '0;
    repeat (2) @(negedge clk_i);
    check("R1", addr_o, 16'h0000);
    format_i = 1'b1;
    #1 check("R1", addr_o, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", addr_o, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [56:0] v;
      v = VEC[i];
      op_i = v[52:50]; mode_i = v[49]; format_i = v[48];
      rf_i = v[47:32]; imm_i = v[31:16];
      @(negedge clk_i);
      op_i = 3'd1;
      check($sformatf("R%0d vec%0d", v[56:53], i), addr_o, v[15:0]);
    end

    // R12: output shows old value during a step, new one after the edge
    op_i = 3'd3; mode_i = 1'b0; format_i = 1'b0; imm_i = 16'h4040;
    @(negedge clk_i);
    op_i = 3'd7; mode_i = 1'b0;
    #1 check("R12 during", addr_o, 16'h4040);
    @(negedge clk_i);
    op_i = 3'd1;
    check("R12 after", addr_o, 16'h4141);

    // R7: access and nop over several cycles with changing inputs
    op_i = 3'd4; mode_i = 1'b1; rf_i = 16'h1111; imm_i = 16'h2222;
    repeat (3) @(negedge clk_i);
    op_i = 3'd1;
    @(negedge clk_i);
    check("R7 hold", addr_o, 16'h4141);

    // R1: asynchronous reset mid-run
    #2 rst_ni = 1'b0;
    #1 check("R1 async", addr_o, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 release", addr_o, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule